// File: doc/BRIEF.md
# Burst-Capable PWM Generator

This block produces one pulse-width-modulated output from a slow reference tick. The period and the high time are both counts of reference ticks, and a 3 MHz tick strobe is the intended use. The tick reaches the block as a one-cycle enable on the system clock. Software programs the block through a small word-addressed register bus. That bus sets the period, the high time, a burst length and a control word, and it reads back a status flag, the number of finished periods and the live tick counter.

Two run modes exist. In continuous mode the output repeats for as long as the run bit stays set. In burst mode the block emits exactly the programmed number of periods. It then clears its own run bit and raises a completion flag. New period and high-time values are taken up only at a period boundary, so a running waveform never shows a shortened or stretched cycle.

Register words are: 0 period, 1 high time, 2 burst length, 3 control, 4 status, 5 completed periods, 6 live counter. Words 4 to 6 are read-only. The control word has run in bit 0, invert in bit 1 and continuous in bit 2.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset the period word reads 999, the high-time word reads 333, the burst length, control and all status words read 0, and `pwm_out` is low.
- R2: Writes to words 0, 1, 2 and 3 are read back unchanged, with control bits [2:0] = {continuous, invert, run}. Reads of word 7 return 0.
- R3: While running, the counter advances by one on each cycle with `ref_tick` high. The raw output is active for the first D ticks of every P-tick period. A high time at or above the period keeps it active throughout, and a high time of 0 keeps it inactive.
- R4: A period value of 0 or 1 behaves as a period of 2.
- R5: With continuous = 0 and a burst length N > 0, exactly N periods are emitted. At the edge that ends the last period, the run bit clears, status bit 0 (done) sets, and word 5 reads N. The other control bits are kept.
- R6: With continuous = 0 and burst length 0, setting the run bit produces no active output. The run bit clears and done sets on the next clock edge, and word 5 reads 0.
- R7: With continuous = 1 the output repeats until the run bit is cleared, whatever the burst length. Word 5 counts every completed period. After a write that clears the run bit, `pwm_out` is at the inactive level from the next sample.
- R8: The invert bit flips the output. When not running, `pwm_out` equals the invert bit.
- R9: A period or high-time write made during a running period takes effect only from the next period boundary.
- R10: The done flag clears when a new run starts.
- R11: Writes to words 4, 5 and 6 have no effect. Word 6 reads the live counter, which holds its value while `ref_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference tick |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output after polarity |

## Verification
The assertions assume that software never writes the control word in the same cycle that a burst ends. In that cycle a bus write would win over the self-clearing of the run bit. They also assume that `ref_tick` is a clean synchronous strobe. The stimulus issues at most one register write per cycle and reprograms period, high time and burst length only while the block is stopped, except in the one test that writes the period mid-run. Bursts are always left to finish before the control word is written again. The sweep covers periods 0 to 6, high times 0 to 7 and bursts of 1 to 3 periods, with both polarities.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] ADR_PERIOD = 3'd0;
  localparam logic [ADR_W-1:0] ADR_HIGH   = 3'd1;
  localparam logic [ADR_W-1:0] ADR_BURST  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_CTRL   = 3'd3;
  localparam logic [ADR_W-1:0] ADR_STAT   = 3'd4;
  localparam logic [ADR_W-1:0] ADR_DONE_N = 3'd5;
  localparam logic [ADR_W-1:0] ADR_LIVE   = 3'd6;

  localparam int CTRL_W = 3;

  // bit 2 continuous, bit 1 invert, bit 0 run
  typedef struct packed {
    logic cont;
    logic inv;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_burst_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PER_RST  = 999,
  parameter int HIGH_RST = 333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              run_start,
  input  logic              run_finish,
  input  logic [DATA_W-1:0] periods_done,
  input  logic [DATA_W-1:0] live_cnt,
  output logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] high_time,
  output logic [DATA_W-1:0] burst_len,
  output ctrl_t             ctrl
);

  logic done;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period    <= DATA_W'(PER_RST);
      high_time <= DATA_W'(HIGH_RST);
      burst_len <= '0;
      ctrl      <= '0;
      done      <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          ADR_PERIOD: period    <= wdata;
          ADR_HIGH:   high_time <= wdata;
          ADR_BURST:  burst_len <= wdata;
          ADR_CTRL:   ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
      if (run_finish && !ctrl_wr) ctrl.run <= 1'b0;
      if (run_finish)     done <= 1'b1;
      else if (run_start) done <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      ADR_PERIOD: rdata = period;
      ADR_HIGH:   rdata = high_time;
      ADR_BURST:  rdata = burst_len;
      ADR_CTRL:   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      ADR_STAT:   rdata = {{(DATA_W-1){1'b0}}, done};
      ADR_DONE_N: rdata = periods_done;
      ADR_LIVE:   rdata = live_cnt;
      default:    rdata = '0;
    endcase
  end

  // R5
  finish_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_finish && !ctrl_wr |=> !ctrl.run && done);

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DATA_W  = 32,
  parameter int MIN_PER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              cont,
  input  logic [DATA_W-1:0] period,
  input  logic [DATA_W-1:0] high_time,
  input  logic [DATA_W-1:0] burst_len,
  output logic              active,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] cur_high,
  output logic [DATA_W-1:0] periods_done,
  output logic              run_start,
  output logic              run_finish
);

  localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);
  localparam logic [DATA_W:0]   ONE_X = (DATA_W+1)'(1);
  localparam logic [DATA_W-1:0] FLOOR = DATA_W'(MIN_PER);

  logic [DATA_W-1:0] cur_per;
  logic [DATA_W-1:0] per_eff;
  logic              wrap;
  logic              empty_burst;
  logic              last_period;

  assign per_eff     = (period < FLOOR) ? FLOOR : period;
  assign wrap        = (cnt == cur_per - ONE);
  assign empty_burst = !cont && (burst_len == '0);
  assign last_period = !cont && (({1'b0, periods_done} + ONE_X) >= {1'b0, burst_len});
  assign run_start   = run && !active && !empty_burst;
  assign run_finish  = run && ((!active && empty_burst) ||
                               (active && tick && wrap && last_period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      cnt          <= '0;
      cur_per      <= FLOOR;
      cur_high     <= '0;
      periods_done <= '0;
    end else if (!run) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      periods_done <= '0;
      cnt          <= '0;
      if (!empty_burst) begin
        active   <= 1'b1;
        cur_per  <= per_eff;
        cur_high <= high_time;
      end
    end else if (tick) begin
      if (wrap) begin
        cnt          <= '0;
        cur_per      <= per_eff;
        cur_high     <= high_time;
        periods_done <= periods_done + ONE;
        if (last_period) active <= 1'b0;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < cur_per);

  // R4
  per_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cur_per >= FLOOR);

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && run && !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_drive.sv
module pwm_drive #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              run,
  input  logic              inv,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] cur_high,
  output logic              pwm_out
);

  logic raw;

  assign raw     = active && run && (cnt < cur_high);
  assign pwm_out = raw ^ inv;

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> pwm_out == inv);

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_burst_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PER_RST  = 999,
  parameter int HIGH_RST = 333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wen,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);

  logic [DATA_W-1:0] period, high_time, burst_len;
  logic [DATA_W-1:0] cnt, cur_high, periods_done;
  logic              active, run_start, run_finish;
  ctrl_t             ctrl;

  pwm_regs #(
    .DATA_W(DATA_W), .PER_RST(PER_RST), .HIGH_RST(HIGH_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wen), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .run_start(run_start),
    .run_finish(run_finish), .periods_done(periods_done), .live_cnt(cnt),
    .period(period), .high_time(high_time), .burst_len(burst_len), .ctrl(ctrl)
  );

  pwm_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .run(ctrl.run), .cont(ctrl.cont),
    .period(period), .high_time(high_time), .burst_len(burst_len),
    .active(active), .cnt(cnt), .cur_high(cur_high), .periods_done(periods_done),
    .run_start(run_start), .run_finish(run_finish)
  );

  pwm_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .active(active), .run(ctrl.run), .inv(ctrl.inv),
    .cnt(cnt), .cur_high(cur_high), .pwm_out(pwm_out)
  );

endmodule

// File: tb/pwm_burst_gen_tb.sv
module pwm_burst_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_burst_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr  = 3'(a);
    bus_wdata = 32'(d);
    bus_wen   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 3'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    int v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int errs;
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    rd_chk(0, 999, "R1 period");
    rd_chk(1, 333, "R1 high");
    rd_chk(2, 0, "R1 burst");
    rd_chk(3, 0, "R1 ctrl");
    rd_chk(4, 0, "R1 status");
    rd_chk(5, 0, "R1 periods");
    rd_chk(6, 0, "R1 live");

    // R2 read back
    wr(0, 5); wr(1, 3); wr(2, 7); wr(3, 6);
    rd_chk(0, 5, "R2 period");
    rd_chk(1, 3, "R2 high");
    rd_chk(2, 7, "R2 burst");
    rd_chk(3, 6, "R2 ctrl");
    rd_chk(7, 0, "R2 word7");
    chk(pwm_out == 1'b1, "R8 idle inverted", pwm_out, 1);

    // R11 status words ignore writes
    wr(4, 1); wr(5, 85); wr(6, 9);
    rd_chk(4, 0, "R11 status");
    rd_chk(5, 0, "R11 periods");
    rd_chk(6, 0, "R11 live");

    // sweep: R3 R4 R5 R8 R10
    for (int p = 0; p < 7; p++) begin
      for (int d = 0; d < 8; d++) begin
        for (int n = 1; n < 4; n++) begin
          int pe;
          int inv;
          pe  = (p < 2) ? 2 : p;
          inv = (p + d) & 1;
          wr(0, p); wr(1, d); wr(2, n);
          wr(3, (inv << 1) | 1);
          chk(pwm_out == inv[0], "R8 before start", pwm_out, inv);
          bus_addr = 3'd4;
          errs = 0;
          for (int k = 0; k < n * pe + 2; k++) begin
            bit e;
            @(posedge clk);
            @(negedge clk);
            if (k == 0) chk(bus_rdata[0] == 1'b0, "R10 done cleared", bus_rdata[0], 0);
            e = ((k < n * pe) && ((k % pe) < d)) ^ inv[0];
            if (pwm_out != e) errs++;
          end
          chk(errs == 0, (p < 2) ? "R4 waveform" : "R3 waveform", errs, 0);
          rd_chk(5, n, "R5 periods");
          rd_chk(4, 1, "R5 done");
          rd_chk(3, inv << 1, "R5 run cleared");
        end
      end
    end

    // R6 empty burst
    wr(1, 2); wr(0, 4); wr(2, 0);
    wr(3, 1);
    errs = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (pwm_out != 1'b0) errs++;
    end
    chk(errs == 0, "R6 no output", errs, 0);
    rd_chk(3, 0, "R6 run cleared");
    rd_chk(4, 1, "R6 done");
    rd_chk(5, 0, "R6 periods");

    // R7 continuous, R9 boundary update
    wr(3, 5);
    errs = 0;
    for (int k = 0; k < 16; k++) begin
      bit e;
      @(posedge clk);
      @(negedge clk);
      e = (k < 4) ? ((k % 4) < 2) : (((k - 4) % 6) < 2);
      if (pwm_out != e) errs++;
      if (k == 1) begin
        bus_addr = 3'd0; bus_wdata = 32'd6; bus_wen = 1'b1;
      end
      if (k == 2) bus_wen = 1'b0;
    end
    chk(errs == 0, "R9 boundary update", errs, 0);
    wr(3, 4);
    chk(pwm_out == 1'b0, "R7 stop", pwm_out, 0);
    rd_chk(5, 3, "R7 periods");

    // R11 counter holds without tick
    ref_tick = 1'b0;
    wr(0, 4); wr(1, 2);
    wr(3, 5);
    errs = 0;
    bus_addr = 3'd6;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (pwm_out != 1'b1 || bus_rdata != 0) errs++;
    end
    chk(errs == 0, "R11 hold", errs, 0);
    ref_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_tick = 1'b0;
    rd(6, v);
    chk(v == 1, "R11 one tick", v, 1);
    chk(pwm_out == 1'b1, "R3 after one tick", pwm_out, 1);
    ref_tick = 1'b1;
    wr(3, 0);
    chk(pwm_out == 1'b0, "R7 stop again", pwm_out, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule